// File: doc/BRIEF.md
# Virtual Address Region Classifier

This block sorts a virtual address into one of four fixed default regions of the address space. It works with either a 32-bit or a 64-bit address space and takes the current privilege level into account. Level 0 is the most privileged and level 3 is user mode. For a region with a fixed mapping, it strips the top address bits to form the physical address and reports a cache attribute. For a region that needs translation, it raises a request for a TLB lookup. Accesses the privilege level may not make, reserved regions and undefined attribute codes are each reported on their own flag.

The classification is combinational. A parameter `REG_OUT` selects whether one output register stage is added. With the default of 1, the results and a valid strobe appear one clock after the inputs.

Top module: `va_region_classifier`

## Requirements
- R1: In 32-bit mode, addresses below 0x80000000 give `region`=0, `tlb_req`=1 and `attr`=1 at every privilege level.
- R2: In 32-bit mode, addresses 0x80000000..0x9FFFFFFF at level 0 give `region`=1, `dm_ok`=1, `attr`=0 and `pa` equal to the address with bits 31:30 cleared.
- R3: In 32-bit mode, addresses 0xA0000000..0xBFFFFFFF at level 0 give `region`=2, `dm_ok`=1, `attr`=1 and `pa` equal to the address with bits 31:30 cleared.
- R4: In 32-bit mode, addresses at or above 0xC0000000 at level 0 give `region`=3, `tlb_req`=1 and `attr`=1.
- R5: At any privilege level other than 0, a nonzero `region` raises `fault` and no other outcome flag. `attr` and `pa` are then zero.
- R6: In 64-bit mode, `region` is address bits 63:62. Regions 0 and 3 are page-mapped: `tlb_req`=1 and `attr`=1, with region 3 allowed only at level 0.
- R7: In 64-bit region 2 at level 0, `dm_ok`=1, `attr` equals address bits 61:60 (0 strongly-ordered uncached, 1 coherent cached, 2 weakly-ordered uncached) and `pa` is the address with bits 63:60 cleared.
- R8: In 64-bit region 2 at level 0, an address with bits 61:60 = 3 raises `attr_err` and gives no translation.
- R9: In 64-bit region 1 at level 0, `reserved`=1 and no translation is made.
- R10: Exactly one of `dm_ok`, `tlb_req`, `fault`, `reserved` and `attr_err` is set for each result. `pa` is zero unless `dm_ok` is set.
- R11: In 32-bit mode, address bits 63:32 have no effect, and `pa` is zero-extended above bit 31.
- R12: With `REG_OUT`=1, `out_valid` follows `in_valid` one clock later. Synchronous reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| mode64 | input | 1 | 1 selects the 64-bit address space, 0 the 32-bit one |
| plv | input | PLV_W | Privilege level, 0 most privileged |
| vaddr | input | VA_W | Virtual address |
| out_valid | output | 1 | Result qualifier |
| region | output | 2 | Decoded region index |
| dm_ok | output | 1 | Fixed-mapping translation is valid |
| tlb_req | output | 1 | TLB lookup requested |
| fault | output | 1 | Privilege access fault |
| reserved | output | 1 | Access to the reserved region |
| attr_err | output | 1 | Undefined cache attribute code |
| attr | output | 2 | Cache attribute |
| pa | output | VA_W | Physical address |

## Verification
The assertions assume that the mode and privilege inputs are driven to known values in every cycle. In the registered variant, they also assume that the previous cycle's privilege level is the one that belongs to the current result. The stimulus meets both assumptions: it changes the inputs only on the falling clock edge and holds them for a full cycle. It sweeps both modes, all four levels and all sixteen values of the top address nibble. In 32-bit mode it also fills the unused upper word with noise.

// File: rtl/va_cls_pkg.sv
package va_cls_pkg;
  localparam int NUM_FLAGS = 5;
  typedef struct packed {
    logic dm_ok;
    logic tlb_req;
    logic fault;
    logic reserved;
    logic attr_err;
  } va_flags_t;
  localparam logic [1:0] ATTR_STRONG_UC = 2'd0;
  localparam logic [1:0] ATTR_COH_C     = 2'd1;
endpackage

// File: rtl/va_cls_region_dec.sv
module va_cls_region_dec #(
  parameter int VA_W     = 64,
  parameter int NARROW_W = 32
) (
  input  logic            mode64,
  input  logic [VA_W-1:0] va,
  output logic [1:0]      region,
  output logic [1:0]      abits
);
  always_comb begin
    if (mode64) begin
      region = va[VA_W-1 -: 2];
    end else if (!va[NARROW_W-1]) begin
      region = 2'd0;
    end else if (va[NARROW_W-2]) begin
      region = 2'd3;
    end else begin
      region = va[NARROW_W-3] ? 2'd2 : 2'd1;
    end
    abits = va[VA_W-3 -: 2];
  end
endmodule

// File: rtl/va_cls_policy.sv
module va_cls_policy #(
  parameter int PLV_W = 2
) (
  input  logic                  mode64,
  input  logic [PLV_W-1:0]      plv,
  input  logic [1:0]            region,
  input  logic [1:0]            abits,
  output va_cls_pkg::va_flags_t flags,
  output logic [1:0]            attr
);
  import va_cls_pkg::*;
  logic is_page, is_fixed, kern_only;
  always_comb begin
    is_page   = (region == 2'd0) || (region == 2'd3);
    is_fixed  = !is_page;
    kern_only = (region != 2'd0);
    flags.fault    = (plv != '0) && kern_only;
    flags.reserved = !flags.fault && mode64 && (region == 2'd1);
    flags.attr_err = !flags.fault && mode64 && (region == 2'd2) && (abits == 2'd3);
    flags.dm_ok    = !flags.fault && !flags.reserved && !flags.attr_err && is_fixed;
    flags.tlb_req  = !flags.fault && is_page;
    if (flags.dm_ok)
      attr = mode64 ? abits : ((region == 2'd2) ? ATTR_COH_C : ATTR_STRONG_UC);
    else if (flags.tlb_req)
      attr = ATTR_COH_C;
    else
      attr = 2'd0;
  end
endmodule

// File: rtl/va_cls_pa_form.sv
module va_cls_pa_form #(
  parameter int VA_W     = 64,
  parameter int NARROW_W = 32
) (
  input  logic            en,
  input  logic            mode64,
  input  logic [VA_W-1:0] va,
  output logic [VA_W-1:0] pa
);
  localparam int WIDE_KEEP   = VA_W - 4;
  localparam int NARROW_KEEP = NARROW_W - 2;
  always_comb begin
    pa = '0;
    if (en) begin
      if (mode64) pa[WIDE_KEEP-1:0]   = va[WIDE_KEEP-1:0];
      else        pa[NARROW_KEEP-1:0] = va[NARROW_KEEP-1:0];
    end
  end
endmodule

// File: rtl/va_cls_out_stage.sv
module va_cls_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] d,
  output logic         out_valid,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          q         <= '0;
        end else begin
          out_valid <= in_valid;
          q         <= d;
        end
      end
    end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign out_valid = in_valid;
      assign q         = d;
    end
  endgenerate
endmodule

// File: rtl/va_region_classifier.sv
module va_region_classifier #(
  parameter int VA_W     = 64,
  parameter int NARROW_W = 32,
  parameter int PLV_W    = 2,
  parameter bit REG_OUT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             mode64,
  input  logic [PLV_W-1:0] plv,
  input  logic [VA_W-1:0]  vaddr,
  output logic             out_valid,
  output logic [1:0]       region,
  output logic             dm_ok,
  output logic             tlb_req,
  output logic             fault,
  output logic             reserved,
  output logic             attr_err,
  output logic [1:0]       attr,
  output logic [VA_W-1:0]  pa
);
  import va_cls_pkg::*;
  localparam int BUS_W = VA_W + 4 + NUM_FLAGS;

  logic [1:0]      c_region, c_abits, c_attr;
  va_flags_t       c_flags, r_flags;
  logic [VA_W-1:0] c_pa;
  logic [BUS_W-1:0] bus_d, bus_q;

  va_cls_region_dec #(.VA_W(VA_W), .NARROW_W(NARROW_W)) u_dec (
    .mode64(mode64), .va(vaddr), .region(c_region), .abits(c_abits));

  va_cls_policy #(.PLV_W(PLV_W)) u_pol (
    .mode64(mode64), .plv(plv), .region(c_region), .abits(c_abits),
    .flags(c_flags), .attr(c_attr));

  va_cls_pa_form #(.VA_W(VA_W), .NARROW_W(NARROW_W)) u_pa (
    .en(c_flags.dm_ok), .mode64(mode64), .va(vaddr), .pa(c_pa));

  assign bus_d = {c_region, c_attr, c_flags, c_pa};

  va_cls_out_stage #(.W(BUS_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .d(bus_d),
    .out_valid(out_valid), .q(bus_q));

  assign {region, attr, r_flags, pa} = bus_q;
  assign dm_ok    = r_flags.dm_ok;
  assign tlb_req  = r_flags.tlb_req;
  assign fault    = r_flags.fault;
  assign reserved = r_flags.reserved;
  assign attr_err = r_flags.attr_err;
endmodule

// File: rtl/va_cls_checker.sv
module va_cls_checker #(
  parameter int VA_W    = 64,
  parameter int PLV_W   = 2,
  parameter bit REG_OUT = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [PLV_W-1:0] plv,
  input logic             out_valid,
  input logic [1:0]       region,
  input logic             dm_ok,
  input logic             tlb_req,
  input logic             fault,
  input logic             reserved,
  input logic             attr_err,
  input logic [1:0]       attr,
  input logic [VA_W-1:0]  pa
);
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({dm_ok, tlb_req, fault, reserved, attr_err}) == 1);
  p_pa_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !dm_ok) |-> (pa == '0));
  p_attr_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dm_ok) |-> (attr != 2'd3));
  p_top_clear_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pa[VA_W-1 -: 4] == 4'd0));
  generate
    if (REG_OUT) begin : g_reg_chk
      p_valid_follow_r12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      p_valid_drop_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      p_user_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(plv) != '0 && region != 2'd0) |-> fault);
    end else begin : g_comb_chk
      p_user_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && plv != '0 && region != 2'd0) |-> fault);
    end
  endgenerate
endmodule

bind va_region_classifier va_cls_checker #(.VA_W(VA_W), .PLV_W(PLV_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .plv(plv), .out_valid(out_valid),
  .region(region), .dm_ok(dm_ok), .tlb_req(tlb_req), .fault(fault),
  .reserved(reserved), .attr_err(attr_err), .attr(attr), .pa(pa));

// File: tb/sim_va_region_classifier.sv
module sim_va_region_classifier;
  localparam int CLK_P = 10;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, mode64 = 1'b0;
  logic [1:0] plv = 2'd0;
  logic [63:0] vaddr = '0;
  logic out_valid, dm_ok, tlb_req, fault, reserved, attr_err;
  logic [1:0] region, attr;
  logic [63:0] pa;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  va_region_classifier u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .mode64(mode64),
    .plv(plv), .vaddr(vaddr), .out_valid(out_valid), .region(region), .dm_ok(dm_ok),
    .tlb_req(tlb_req), .fault(fault), .reserved(reserved), .attr_err(attr_err),
    .attr(attr), .pa(pa));

  task automatic check(input string tag, input logic [77:0] act, input logic [77:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic one(input bit m, input int p, input logic [63:0] va);
    logic [31:0] a;
    int rg;
    logic e_dm, e_tlb, e_flt, e_rsv, e_aer;
    logic [1:0] e_attr, ab;
    logic [63:0] e_pa;
    string tag;
    e_dm = 0; e_tlb = 0; e_flt = 0; e_rsv = 0; e_aer = 0; e_attr = 0; e_pa = 0;
    a  = va[31:0];
    ab = 2'((va >> 60) % 4);
    if (!m) begin
      if (a < 32'h8000_0000) rg = 0;
      else if (a < 32'hA000_0000) rg = 1;
      else if (a < 32'hC000_0000) rg = 2;
      else rg = 3;
    end else rg = int'(va >> 62);
    if (p != 0 && rg != 0) begin e_flt = 1; tag = "R5"; end
    else if (!m) begin
      case (rg)
        0: begin e_tlb = 1; e_attr = 1; tag = "R1"; end
        1: begin e_dm = 1; e_attr = 0; e_pa = 64'(a % 32'h4000_0000); tag = "R2"; end
        2: begin e_dm = 1; e_attr = 1; e_pa = 64'(a % 32'h4000_0000); tag = "R3"; end
        default: begin e_tlb = 1; e_attr = 1; tag = "R4"; end
      endcase
    end else begin
      case (rg)
        1: begin e_rsv = 1; tag = "R9"; end
        2: if (ab == 2'd3) begin e_aer = 1; tag = "R8"; end
           else begin e_dm = 1; e_attr = ab; e_pa = va % 64'h1000_0000_0000_0000; tag = "R7"; end
        default: begin e_tlb = 1; e_attr = 1; tag = "R6"; end
      endcase
    end
    if (!m) tag = {tag, " R11"};
    @(negedge clk);
    mode64 = m; plv = 2'(p); vaddr = va; in_valid = 1'b1;
    @(negedge clk);
    check(tag, {out_valid, 2'(region), dm_ok, tlb_req, fault, reserved, attr_err, attr, pa},
               {1'b1, 2'(rg), e_dm, e_tlb, e_flt, e_rsv, e_aer, e_attr, e_pa});
    // R10: pa zero unless a valid fixed translation
    if (!e_dm) check("R10", {14'd0, pa}, 78'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 reset", {77'd0, out_valid}, 78'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R12 idle", {77'd0, out_valid}, 78'd0);
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 16; n++)
          for (int k = 0; k < 4; k++) begin
            logic [63:0] va;
            logic [59:0] low;
            case (k)
              0: low = '0;
              1: low = 60'h123_4567_89AB_CDEF;
              2: low = '1;
              default: low = 60'h5A5_A5A5_0F0F_3C3C;
            endcase
            if (m == 1) va = {4'(n), low};
            else va = {32'h9E37_79B9 ^ (32'(k) << 8) ^ 32'(n), 4'(n), low[27:0]};
            one(m[0], p, va);
          end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R12 drop", {77'd0, out_valid}, 78'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule